// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block keeps one processor's private cache coherent with its peers on an atomic snooping bus. It uses a four-state invalidation protocol:

- **Modified**: the only copy, and it differs from memory.
- **Exclusive**: the only copy, and it matches memory.
- **Shared**: possibly one of several copies, all matching memory.
- **Invalid**: the line holds nothing.

The cache is direct-mapped and holds one data word per line. The block contains the state/tag/data store, the processor-side sequencer and the snoop responder.

Processor requests enter through a valid/ready handshake.

- A request is accepted on a cycle where `cpu_req_valid` and `cpu_req_ready` are both high.
- Ready is low while a miss is in progress and in any cycle that carries a snooped transaction.
- The requester must hold its request stable until it is accepted.
- Every accepted request produces exactly one response pulse on `cpu_rsp_valid`. The response has no back-pressure: the requester must take it in that cycle.

Misses go through an external arbiter. The block raises `bus_req` and places its address phase on the cycle it sees `bus_gnt`. Once granted, it owns the bus until its fill data returns.

Snooped transactions from other caches arrive on the `snp_*` pins. The block's own transactions are never presented back to it there. Peer coherence is kept with two signals:

- A shared vote, meant to be wired-OR with every other cache's vote, goes out on `shared_out`.
- Data from a dirty line is supplied to the requester on the `flush_*` pins.

For its own read miss, the block samples the wired-OR result on `shared_in`. It uses that vote to pick the Shared or Exclusive fill state.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid and `cpu_req_ready` is high. `shared_out`, `flush_valid`, `bus_req` and `cpu_rsp_valid` are all low, and the first read of any address issues a bus read.
- R2: A read miss whose shared vote (`shared_in`) is low in the first cycle after its address phase fills in Exclusive. A later write to that line completes with no bus command.
- R3: A read miss whose shared vote is high in the first cycle after its address phase fills in Shared. A later write to that line issues a read-for-ownership (`bus_out_cmd` = 2) and leaves the line Modified.
- R4: A read hit answers with the stored word one cycle after acceptance and issues no bus command. A write hit to an Exclusive or Modified line answers with the written word.
- R5: A snooped bus read (`snp_cmd` = 1) that matches a valid line raises `shared_out` in the cycle after the snoop.
- R6: A snooped bus read that matches a Modified line raises `flush_valid` one cycle later, carrying the line's address and data. The line drops to Shared.
- R7: A snooped bus read that matches an Exclusive line drops it to Shared with no flush.
- R8: A snooped read-for-ownership (`snp_cmd` = 2) that matches a valid line invalidates it and does not vote shared. A Modified line flushes its data first.
- R9: A snooped transaction that matches no valid line (a tag mismatch or an Invalid line) neither votes nor flushes, and leaves the line's state unchanged.
- R10: A miss whose direct-mapped victim is Modified under another tag first issues a write-back (`bus_out_cmd` = 3) with the victim's address and data, then issues the miss command.
- R11: A write miss issues a read-for-ownership (`bus_out_cmd` = 2), fills the line in Modified with the write data, and answers with that data.
- R12: `cpu_req_ready` is low in a cycle with a snooped transaction and while a miss is outstanding. A bus request starts only from an accepted processor request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Request can be accepted this cycle |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address; low IDX_W bits select the line |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | DATA_W | Read data, or the written word for writes |
| bus_req | output | 1 | Request for the snooping bus |
| bus_gnt | input | 1 | Grant; the address phase goes out in this cycle |
| bus_out_valid | output | 1 | Own address phase valid |
| bus_out_cmd | output | 2 | 1 read, 2 read-for-ownership, 3 write-back |
| bus_out_addr | output | ADDR_W | Own transaction address |
| bus_out_data | output | DATA_W | Write-back data |
| bus_fill_valid | input | 1 | Fill data for own miss; no earlier than one cycle after the address phase |
| bus_fill_data | input | DATA_W | Fill data word |
| snp_valid | input | 1 | Another cache's address phase |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_out_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| shared_out | output | 1 | This cache's shared vote, one cycle after the snoop |
| shared_in | input | 1 | Wired-OR shared vote from all peers |
| flush_valid | output | 1 | Cache-to-cache data supply valid |
| flush_addr | output | ADDR_W | Address of flushed line |
| flush_data | output | DATA_W | Flushed data |

## Verification
One address is driven through every state by a fixed series of steps:

- A read fill with the peer vote low, then a silent upgrade.
- A snooped read on the dirty copy.
- An upgrade from Shared.
- A snooped ownership request.
- A refill with the vote high.

Following the line this way tells apart the two fill states and the Modified-versus-Exclusive flush decision. The peer vote is driven only in the single cycle after each address phase, and the fill data arrives a cycle later, so a design that samples the vote at fill time rather than at the fixed cycle gives the wrong fill state.

Further patterns cover the remaining paths:

- A snoop to the same index under another tag separates tag matching from index matching.
- A miss onto a dirty victim checks the order of write-back and miss.
- A write miss covers the ownership fill.
- A snoop that collides with a processor request checks the stall.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_t;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_RD    = 2'd1,
    CMD_RDX   = 2'd2,
    CMD_FLUSH = 2'd3
  } bus_cmd_t;

  typedef enum logic [1:0] {
    C_IDLE = 2'd0,
    C_REQ  = 2'd1,
    C_WAIT = 2'd2
  } ctl_t;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output mesi_t             a_state,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output mesi_t             b_state,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  mesi_t             wr_state,
  input  logic              wr_line,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int NLINES = 1 << IDX_W;

  mesi_t             st_q  [NLINES];
  logic [TAG_W-1:0]  tag_q [NLINES];
  logic [DATA_W-1:0] dat_q [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[g] <= ST_I;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        st_q[g] <= wr_state;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_line && wr_idx == IDX_W'(g)) begin
        tag_q[g] <= wr_tag;
        dat_q[g] <= wr_data;
      end
    end
  end

  assign a_state = st_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_data  = dat_q[a_idx];
  assign b_state = st_q[b_idx];
  assign b_tag   = tag_q[b_idx];
  assign b_data  = dat_q[b_idx];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  mesi_t             line_state,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              upd_en,
  output mesi_t             upd_state,
  output logic              shared_out,
  output logic              flush_valid,
  output logic [ADDR_W-1:0] flush_addr,
  output logic [DATA_W-1:0] flush_data
);
  logic hit, vote, flush;

  assign hit = snp_valid && (line_state != ST_I) &&
               (line_tag == snp_addr[ADDR_W-1:ADDR_W-TAG_W]);

  always_comb begin
    vote      = 1'b0;
    flush     = 1'b0;
    upd_en    = 1'b0;
    upd_state = line_state;
    if (hit) begin
      unique case (snp_cmd)
        CMD_RD: begin
          vote      = 1'b1;
          flush     = (line_state == ST_M);
          upd_en    = (line_state != ST_S);
          upd_state = ST_S;
        end
        CMD_RDX: begin
          flush     = (line_state == ST_M);
          upd_en    = 1'b1;
          upd_state = ST_I;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shared_out  <= 1'b0;
      flush_valid <= 1'b0;
      flush_addr  <= '0;
      flush_data  <= '0;
    end else begin
      shared_out  <= vote;
      flush_valid <= flush;
      if (flush) begin
        flush_addr <= snp_addr;
        flush_data <= line_data;
      end
    end
  end
endmodule

// File: rtl/mesi_cpu_fsm.sv
module mesi_cpu_fsm
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  input  logic              snp_valid,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              out_valid,
  output logic [1:0]        out_cmd,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  input  logic              bus_fill_valid,
  input  logic [DATA_W-1:0] bus_fill_data,
  input  logic              shared_in,
  output logic [IDX_W-1:0]  a_idx,
  input  mesi_t             a_state,
  input  logic [ADDR_W-IDX_W-1:0] a_tag,
  input  logic [DATA_W-1:0] a_data,
  output logic              wr_en,
  output mesi_t             wr_state,
  output logic              wr_line,
  output logic [ADDR_W-IDX_W-1:0] wr_tag,
  output logic [DATA_W-1:0] wr_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  ctl_t              st_q, nxt;
  logic              lat_write;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic              first_q, shr_q, go_wait;
  logic              rsp_set;
  logic [DATA_W-1:0] rsp_val;
  logic [TAG_W-1:0]  cur_tag;
  logic              hit, accept, victim_dirty, sh;

  assign a_idx   = (st_q == C_IDLE) ? cpu_req_addr[IDX_W-1:0] : lat_addr[IDX_W-1:0];
  assign cur_tag = (st_q == C_IDLE) ? cpu_req_addr[ADDR_W-1:IDX_W] : lat_addr[ADDR_W-1:IDX_W];
  assign hit     = (a_state != ST_I) && (a_tag == cur_tag);
  assign cpu_req_ready = (st_q == C_IDLE) && !snp_valid;
  assign accept  = cpu_req_ready && cpu_req_valid;
  assign victim_dirty = (a_state == ST_M) && (a_tag != lat_addr[ADDR_W-1:IDX_W]);
  assign sh      = first_q ? shared_in : shr_q;
  assign wr_tag  = cur_tag;

  always_comb begin
    nxt       = st_q;
    bus_req   = 1'b0;
    out_valid = 1'b0;
    out_cmd   = CMD_NONE;
    out_addr  = lat_addr;
    out_data  = a_data;
    wr_en     = 1'b0;
    wr_state  = ST_I;
    wr_line   = 1'b0;
    wr_data   = lat_wdata;
    rsp_set   = 1'b0;
    rsp_val   = a_data;
    go_wait   = 1'b0;
    unique case (st_q)
      C_IDLE: begin
        if (accept) begin
          if (hit && !cpu_req_write) begin
            rsp_set = 1'b1;
          end else if (hit && (a_state == ST_E || a_state == ST_M)) begin
            wr_en    = 1'b1;
            wr_state = ST_M;
            wr_line  = 1'b1;
            wr_data  = cpu_req_wdata;
            rsp_set  = 1'b1;
            rsp_val  = cpu_req_wdata;
          end else begin
            nxt = C_REQ;
          end
        end
      end
      C_REQ: begin
        bus_req = 1'b1;
        if (bus_gnt) begin
          out_valid = 1'b1;
          if (victim_dirty) begin
            out_cmd  = CMD_FLUSH;
            out_addr = {a_tag, lat_addr[IDX_W-1:0]};
            wr_en    = 1'b1;
            wr_state = ST_I;
          end else begin
            out_cmd = lat_write ? CMD_RDX : CMD_RD;
            nxt     = C_WAIT;
            go_wait = 1'b1;
          end
        end
      end
      C_WAIT: begin
        if (bus_fill_valid) begin
          wr_en    = 1'b1;
          wr_line  = 1'b1;
          wr_data  = lat_write ? lat_wdata : bus_fill_data;
          wr_state = lat_write ? ST_M : (sh ? ST_S : ST_E);
          rsp_set  = 1'b1;
          rsp_val  = wr_data;
          nxt      = C_IDLE;
        end
      end
      default: nxt = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= C_IDLE;
      first_q       <= 1'b0;
      shr_q         <= 1'b0;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_rdata <= '0;
      lat_write     <= 1'b0;
      lat_addr      <= '0;
      lat_wdata     <= '0;
    end else begin
      st_q          <= nxt;
      first_q       <= go_wait;
      if (first_q) shr_q <= shared_in;
      cpu_rsp_valid <= rsp_set;
      if (rsp_set) cpu_rsp_rdata <= rsp_val;
      if (accept) begin
        lat_write <= cpu_req_write;
        lat_addr  <= cpu_req_addr;
        lat_wdata <= cpu_req_wdata;
      end
    end
  end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_out_valid,
  output logic [1:0]        bus_out_cmd,
  output logic [ADDR_W-1:0] bus_out_addr,
  output logic [DATA_W-1:0] bus_out_data,
  input  logic              bus_fill_valid,
  input  logic [DATA_W-1:0] bus_fill_data,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              shared_out,
  input  logic              shared_in,
  output logic              flush_valid,
  output logic [ADDR_W-1:0] flush_addr,
  output logic [DATA_W-1:0] flush_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  a_idx;
  mesi_t             a_state, b_state;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data;
  logic              cpu_wr_en, cpu_wr_line;
  mesi_t             cpu_wr_state;
  logic [TAG_W-1:0]  cpu_wr_tag;
  logic [DATA_W-1:0] cpu_wr_data;
  logic              snp_upd;
  mesi_t             snp_upd_state;

  logic              st_wr_en;
  logic [IDX_W-1:0]  st_wr_idx;
  mesi_t             st_wr_state;

  assign st_wr_en    = snp_upd | cpu_wr_en;
  assign st_wr_idx   = snp_upd ? snp_addr[IDX_W-1:0] : a_idx;
  assign st_wr_state = snp_upd ? snp_upd_state : cpu_wr_state;

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_idx    (a_idx),
    .a_state  (a_state),
    .a_tag    (a_tag),
    .a_data   (a_data),
    .b_idx    (snp_addr[IDX_W-1:0]),
    .b_state  (b_state),
    .b_tag    (b_tag),
    .b_data   (b_data),
    .wr_en    (st_wr_en),
    .wr_idx   (st_wr_idx),
    .wr_state (st_wr_state),
    .wr_line  (cpu_wr_line && !snp_upd),
    .wr_tag   (cpu_wr_tag),
    .wr_data  (cpu_wr_data)
  );

  mesi_snoop_unit #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .clk         (clk),
    .rst_n       (rst_n),
    .snp_valid   (snp_valid),
    .snp_cmd     (snp_cmd),
    .snp_addr    (snp_addr),
    .line_state  (b_state),
    .line_tag    (b_tag),
    .line_data   (b_data),
    .upd_en      (snp_upd),
    .upd_state   (snp_upd_state),
    .shared_out  (shared_out),
    .flush_valid (flush_valid),
    .flush_addr  (flush_addr),
    .flush_data  (flush_data)
  );

  mesi_cpu_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_req_valid  (cpu_req_valid),
    .cpu_req_ready  (cpu_req_ready),
    .cpu_req_write  (cpu_req_write),
    .cpu_req_addr   (cpu_req_addr),
    .cpu_req_wdata  (cpu_req_wdata),
    .cpu_rsp_valid  (cpu_rsp_valid),
    .cpu_rsp_rdata  (cpu_rsp_rdata),
    .snp_valid      (snp_valid),
    .bus_req        (bus_req),
    .bus_gnt        (bus_gnt),
    .out_valid      (bus_out_valid),
    .out_cmd        (bus_out_cmd),
    .out_addr       (bus_out_addr),
    .out_data       (bus_out_data),
    .bus_fill_valid (bus_fill_valid),
    .bus_fill_data  (bus_fill_data),
    .shared_in      (shared_in),
    .a_idx          (a_idx),
    .a_state        (a_state),
    .a_tag          (a_tag),
    .a_data         (a_data),
    .wr_en          (cpu_wr_en),
    .wr_state       (cpu_wr_state),
    .wr_line        (cpu_wr_line),
    .wr_tag         (cpu_wr_tag),
    .wr_data        (cpu_wr_data)
  );
endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       snp_valid,
  input logic [1:0] snp_cmd,
  input logic       shared_out,
  input logic       flush_valid,
  input logic       bus_out_valid,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic       cpu_req_valid,
  input logic       cpu_req_ready
);
  AST_VOTE_AFTER_SNOOP_READ: assert property (@(posedge clk) disable iff (!rst_n)
    shared_out |-> $past(snp_valid && snp_cmd == 2'd1)); // R5

  AST_FLUSH_AFTER_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> $past(snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2))); // R6

  AST_NO_VOTE_ON_OWNERSHIP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(snp_valid && snp_cmd == 2'd2) |-> !shared_out); // R8

  AST_ADDR_ONLY_WHEN_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_out_valid |-> (bus_gnt && bus_req)); // R10

  AST_BUS_REQ_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(cpu_req_valid && cpu_req_ready)); // R12
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .snp_valid     (snp_valid),
  .snp_cmd       (snp_cmd),
  .shared_out    (shared_out),
  .flush_valid   (flush_valid),
  .bus_out_valid (bus_out_valid),
  .bus_req       (bus_req),
  .bus_gnt       (bus_gnt),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_ready (cpu_req_ready)
);

// File: tb/test_mesi_snoop_ctrl.sv
`timescale 1ns/1ps
module test_mesi_snoop_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          cpu_req_valid, cpu_req_ready, cpu_req_write;
  logic [AW-1:0] cpu_req_addr;
  logic [DW-1:0] cpu_req_wdata;
  logic          cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_rdata;
  logic          bus_req, bus_gnt, bus_out_valid;
  logic [1:0]    bus_out_cmd;
  logic [AW-1:0] bus_out_addr;
  logic [DW-1:0] bus_out_data;
  logic          bus_fill_valid;
  logic [DW-1:0] bus_fill_data;
  logic          snp_valid;
  logic [1:0]    snp_cmd;
  logic [AW-1:0] snp_addr;
  logic          shared_out, shared_in, flush_valid;
  logic [AW-1:0] flush_addr;
  logic [DW-1:0] flush_data;

  mesi_snoop_ctrl i_mesi_snoop_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_rdata(cpu_rsp_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_out_valid(bus_out_valid), .bus_out_cmd(bus_out_cmd),
    .bus_out_addr(bus_out_addr), .bus_out_data(bus_out_data),
    .bus_fill_valid(bus_fill_valid), .bus_fill_data(bus_fill_data),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .shared_out(shared_out), .shared_in(shared_in),
    .flush_valid(flush_valid), .flush_addr(flush_addr), .flush_data(flush_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [1:0]    cmd;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string         tag;
  } bus_item_t;
  typedef struct {
    logic [DW-1:0] data;
    string         tag;
  } rsp_item_t;

  bus_item_t bus_q[$];
  rsp_item_t rsp_q[$];
  bus_item_t bi;
  rsp_item_t ri;
  int        rsp_seen = 0;
  logic      share_vote = 1'b0;
  int        fill_cnt = 0;
  logic [AW-1:0] fill_addr = '0;
  bit        shr_pending = 1'b0;

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return {a, ~a};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Bus model: grants at once, votes only in the cycle after the address phase,
  // returns fill data two cycles after the address phase.
  initial begin
    bus_gnt = 1'b0; bus_fill_valid = 1'b0; bus_fill_data = '0; shared_in = 1'b0;
    forever begin
      @(negedge clk); #0.2;
      bus_fill_valid = 1'b0;
      shared_in      = 1'b0;
      if (shr_pending) begin shared_in = share_vote; shr_pending = 1'b0; end
      if (fill_cnt == 1) begin bus_fill_valid = 1'b1; bus_fill_data = mem_val(fill_addr); end
      if (fill_cnt > 0) fill_cnt--;
      bus_gnt = bus_req;
      #0.2;
      if (bus_out_valid && (bus_out_cmd == 2'd1 || bus_out_cmd == 2'd2)) begin
        fill_cnt = 2; fill_addr = bus_out_addr; shr_pending = 1'b1;
      end
    end
  end

  // Monitor: pops expected bus commands and responses.
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        if (bus_out_valid) begin
          if (bus_q.size() == 0) begin
            check(1'b0, "R2", "unexpected bus command", 32'(bus_out_cmd), 0);
          end else begin
            bi = bus_q.pop_front();
            check(bus_out_cmd == bi.cmd, bi.tag, "bus cmd", 32'(bus_out_cmd), 32'(bi.cmd));
            check(bus_out_addr == bi.addr, bi.tag, "bus addr", 32'(bus_out_addr), 32'(bi.addr));
            if (bi.cmd == 2'd3)
              check(bus_out_data == bi.data, bi.tag, "write-back data", 32'(bus_out_data), 32'(bi.data));
          end
        end
        if (cpu_rsp_valid) begin
          if (rsp_q.size() == 0) begin
            check(1'b0, "R4", "unexpected response", 32'(cpu_rsp_rdata), 0);
          end else begin
            ri = rsp_q.pop_front();
            check(cpu_rsp_rdata == ri.data, ri.tag, "response data", 32'(cpu_rsp_rdata), 32'(ri.data));
          end
          rsp_seen++;
        end
      end
    end
  end

  task automatic exp_bus(input logic [1:0] c, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input string tag);
    bus_item_t it;
    it.cmd = c; it.addr = a; it.data = d; it.tag = tag;
    bus_q.push_back(it);
  endtask

  task automatic exp_rsp(input logic [DW-1:0] d, input string tag);
    rsp_item_t it;
    it.data = d; it.tag = tag;
    rsp_q.push_back(it);
  endtask

  task automatic cpu_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic [DW-1:0] exp, input string tag);
    int target;
    exp_rsp(exp, tag);
    target = rsp_seen + 1;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = wd;
    forever begin
      #1;
      if (cpu_req_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    cpu_req_valid = 1'b0;
    wait (rsp_seen >= target);
    check(bus_q.size() == 0, tag, "missing bus command", 32'(bus_q.size()), 0);
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input bit exp_vote,
                       input bit exp_flush, input logic [DW-1:0] exp_data, input string tag);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0; snp_cmd = 2'd0;
    #1;
    check(shared_out == exp_vote, tag, "shared vote", 32'(shared_out), 32'(exp_vote));
    check(flush_valid == exp_flush, tag, "flush valid", 32'(flush_valid), 32'(exp_flush));
    if (exp_flush) begin
      check(flush_addr == a, tag, "flush addr", 32'(flush_addr), 32'(a));
      check(flush_data == exp_data, tag, "flush data", 32'(flush_data), 32'(exp_data));
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int target;
    rst_n = 1'b0; cpu_req_valid = 1'b0; cpu_req_write = 1'b0; cpu_req_addr = '0;
    cpu_req_wdata = '0; snp_valid = 1'b0; snp_cmd = 2'd0; snp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(cpu_req_ready == 1'b1, "R1", "ready after reset", 32'(cpu_req_ready), 1);
    check(shared_out == 1'b0, "R1", "vote after reset", 32'(shared_out), 0);
    check(flush_valid == 1'b0, "R1", "flush after reset", 32'(flush_valid), 0);
    check(bus_req == 1'b0, "R1", "bus_req after reset", 32'(bus_req), 0);
    check(cpu_rsp_valid == 1'b0, "R1", "rsp after reset", 32'(cpu_rsp_valid), 0);

    // R1/R2: first read misses, vote low -> Exclusive
    share_vote = 1'b0;
    exp_bus(2'd1, 8'h10, '0, "R1");
    cpu_op(1'b0, 8'h10, '0, mem_val(8'h10), "R2");
    // R2: silent upgrade Exclusive -> Modified
    cpu_op(1'b1, 8'h10, 16'hA1A1, 16'hA1A1, "R2");
    // R4: read hit
    cpu_op(1'b0, 8'h10, '0, 16'hA1A1, "R4");
    // R5/R6: snooped read on Modified line
    snoop(2'd1, 8'h10, 1'b1, 1'b1, 16'hA1A1, "R6");
    // R6/R3: line is Shared now, write needs ownership
    exp_bus(2'd2, 8'h10, '0, "R6");
    cpu_op(1'b1, 8'h10, 16'hB2B2, 16'hB2B2, "R3");
    // R8: snooped ownership request on Modified line
    snoop(2'd2, 8'h10, 1'b0, 1'b1, 16'hB2B2, "R8");
    // R8/R3: line invalid -> miss; vote high -> Shared
    share_vote = 1'b1;
    exp_bus(2'd1, 8'h10, '0, "R8");
    cpu_op(1'b0, 8'h10, '0, mem_val(8'h10), "R3");
    share_vote = 1'b0;
    exp_bus(2'd2, 8'h10, '0, "R3");
    cpu_op(1'b1, 8'h10, 16'hC3C3, 16'hC3C3, "R3");
    // R9: same index, other tag -> no vote, no flush, unchanged
    snoop(2'd1, 8'h14, 1'b0, 1'b0, '0, "R9");
    cpu_op(1'b0, 8'h10, '0, 16'hC3C3, "R9");
    // R10: dirty victim written back before the miss
    exp_bus(2'd3, 8'h10, 16'hC3C3, "R10");
    exp_bus(2'd1, 8'h14, '0, "R10");
    cpu_op(1'b0, 8'h14, '0, mem_val(8'h14), "R10");
    // R7: snooped read on Exclusive: vote, no flush, drops to Shared
    snoop(2'd1, 8'h14, 1'b1, 1'b0, '0, "R7");
    exp_bus(2'd2, 8'h14, '0, "R7");
    cpu_op(1'b1, 8'h14, 16'hD4D4, 16'hD4D4, "R7");
    // R9: snoop on an Invalid line
    snoop(2'd1, 8'h21, 1'b0, 1'b0, '0, "R9");
    // R11: write miss fills Modified with write data
    exp_bus(2'd2, 8'h22, '0, "R11");
    cpu_op(1'b1, 8'h22, 16'hE5E5, 16'hE5E5, "R11");
    cpu_op(1'b0, 8'h22, '0, 16'hE5E5, "R11");

    // R12: snoop in the same cycle stalls the request
    exp_rsp(16'hE5E5, "R12");
    target = rsp_seen + 1;
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 8'h30;
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = 8'h22;
    #1;
    check(cpu_req_ready == 1'b0, "R12", "ready during snoop", 32'(cpu_req_ready), 0);
    @(negedge clk);
    snp_valid = 1'b0; snp_cmd = 2'd0;
    #1;
    check(cpu_req_ready == 1'b1, "R12", "ready after snoop", 32'(cpu_req_ready), 1);
    check(shared_out == 1'b0, "R9", "vote on snoop miss", 32'(shared_out), 0);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    wait (rsp_seen >= target);

    // R12: ready low while a miss is outstanding
    exp_bus(2'd1, 8'h33, '0, "R12");
    exp_rsp(mem_val(8'h33), "R12");
    target = rsp_seen + 1;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = 8'h33;
    #1;
    check(cpu_req_ready == 1'b1, "R12", "ready before miss", 32'(cpu_req_ready), 1);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    #1;
    check(cpu_req_ready == 1'b0, "R12", "ready during miss", 32'(cpu_req_ready), 0);
    wait (rsp_seen >= target);
    check(bus_q.size() == 0, "R12", "missing bus command", 32'(bus_q.size()), 0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule